// File: doc/BRIEF.md
# Energy-to-Pulse Converter

This block turns a stream of signed power samples into a train of output pulses. Each pulse stands for one fixed quantum of real energy. Every accepted sample is multiplied by an unsigned pulse-rate factor, and the product is added into a private signed energy residue. Whenever the residue reaches plus or minus one quantum (2^TH_SHIFT), the quantum is taken out of the residue and one pulse is owed. Whatever is left below the quantum is kept, so no energy is lost between pulses.

Owed pulses are held in a signed backlog counter of bounded depth. They are then played out one at a time, with a programmable width and an idle gap of at least that width between pulses. Two output formats are available. In the first, one line pulses active-low and the other shows the sign of the energy. In the second, the two lines drive a stepper motor through a four-state Gray code.

The sample port never applies back-pressure: `s_ready` stays high, and a sample is taken on every clock edge where `s_valid` is high. If samples arrive faster than pulses can drain, the backlog fills. The residue then clips at its limits instead of wrapping around.

Top module: `energy_pulse_gen`

## Requirements
- R1: `s_ready` is high out of reset. On each rising edge with `s_valid` high, the product of `s_power` (two's complement) and `pulse_rate` (unsigned) is added to the residue.
- R2: For a stream of single-sign energy E that starts from a cleared residue, the number of pulses is floor(|E| / 2^TH_SHIFT). All of these pulses have the sign of E.
- R3: In pulse mode (`step_mode` = 0), `out_b` is 1 for a negative-energy pulse and 0 for a positive one. It holds that value for the whole time `out_a` is low.
- R4: Energy below one quantum stays in the residue and adds to later samples of either sign.
- R5: A sample worth several quanta yields one pulse per quantum. The pulses are issued one after another and are never merged.
- R6: In pulse mode, `out_a` is low for exactly `pulse_width` clock cycles per pulse. A width of 0 acts as 1.
- R7: Between two pulses, `out_a` stays high for at least the effective pulse width.
- R8: In stepper mode (`step_mode` = 1), {`out_a`,`out_b`} moves one state per quantum. Positive energy steps it forward along 00, 01, 11, 10, 00. Negative energy steps it backward. Exactly one bit changes per step.
- R9: At most PEND_MAX pulses are owed at once. While the backlog is full, the residue clips at 2^(ACC_W-1)-1 or -2^(ACC_W-1) instead of wrapping. After the backlog drains, the clipped residue still yields its pulses and leaves its remainder.
- R10: Reset clears the residue, the backlog and the stepper state. After reset, `out_a` is 1 and `out_b` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| s_valid | input | 1 | Power sample valid |
| s_ready | output | 1 | Sample accepted (always high) |
| s_power | input | PWR_W | Signed power sample |
| pulse_rate | input | RATE_W | Unsigned scale applied to each sample |
| pulse_width | input | PW_W | Pulse low time and minimum gap, in cycles |
| step_mode | input | 1 | 0: pulse plus sign, 1: stepper Gray drive |
| out_a | output | 1 | Active-low pulse, or stepper phase bit 1 |
| out_b | output | 1 | Energy sign, or stepper phase bit 0 |

## Verification
The bench builds the block with 6-bit samples, a 3-bit rate, an 11-bit residue, a quantum of 16 and a backlog of 15. With these values every combination of sample and rate (512 in all) is swept, and the pulse count of each is compared with the exact quotient. Saturation of the residue comes within reach after only a few dozen samples. Long pulse widths hold the backlog full while the residue clips. Separate sequences cover carry of the remainder across samples of both signs, and forward and backward stepping.

// File: rtl/energy_pulse_pkg.sv
package energy_pulse_pkg;

  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_ACT  = 2'd1,
    SQ_GAP  = 2'd2
  } seq_state_t;

  // Stepper phase order {a,b}: 00 -> 01 -> 11 -> 10 -> 00 when going forward.
  function automatic logic [1:0] gray_step(input logic [1:0] ph, input logic back);
    logic [1:0] nx;
    unique case (ph)
      2'b00:   nx = back ? 2'b10 : 2'b01;
      2'b01:   nx = back ? 2'b00 : 2'b11;
      2'b11:   nx = back ? 2'b01 : 2'b10;
      default: nx = back ? 2'b11 : 2'b00;
    endcase
    return nx;
  endfunction

endpackage

// File: rtl/energy_pulse_accum.sv
module energy_pulse_accum #(
  parameter int PWR_W    = 24,
  parameter int RATE_W   = 16,
  parameter int ACC_W    = 42,
  parameter int TH_SHIFT = 30,
  parameter int PEND_MAX = 15,
  parameter int PQ_W     = 5
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     smp_valid,
  input  logic signed [PWR_W-1:0]  smp,
  input  logic [RATE_W-1:0]        rate,
  input  logic                     pop,
  output logic signed [ACC_W-1:0]  acc_q,
  output logic signed [PQ_W-1:0]   pend_q
);

  localparam int PROD_W = PWR_W + RATE_W + 1;
  localparam int SUM_W  = ACC_W + 2;
  localparam logic signed [SUM_W-1:0] TH_S   = SUM_W'(1) << TH_SHIFT;
  localparam logic signed [SUM_W-1:0] ACC_HI = (SUM_W'(1) << (ACC_W-1)) - SUM_W'(1);
  localparam logic signed [SUM_W-1:0] ACC_LO = -(SUM_W'(1) << (ACC_W-1));
  localparam logic signed [PQ_W-1:0]  PMAX   = PQ_W'(PEND_MAX);
  localparam logic signed [PQ_W-1:0]  PMIN   = -PQ_W'(PEND_MAX);
  localparam logic signed [PQ_W-1:0]  P_ONE  = PQ_W'(1);

  logic signed [PROD_W-1:0] prod;
  logic signed [SUM_W-1:0]  acc_ext, add_term, sum;
  logic signed [ACC_W-1:0]  acc_d;
  logic signed [PQ_W-1:0]   pend_d;
  logic                     take_pos, take_neg;

  always_comb begin
    prod     = PROD_W'(smp) * PROD_W'($signed({1'b0, rate}));
    acc_ext  = SUM_W'(acc_q);
    add_term = smp_valid ? SUM_W'(prod) : '0;
    take_pos = (acc_ext >= TH_S)  && (pend_q < PMAX);
    take_neg = (acc_ext <= -TH_S) && (pend_q > PMIN);
    sum = acc_ext + add_term;
    if (take_pos) sum = sum - TH_S;
    if (take_neg) sum = sum + TH_S;
    if (sum > ACC_HI)      acc_d = ACC_HI[ACC_W-1:0];
    else if (sum < ACC_LO) acc_d = ACC_LO[ACC_W-1:0];
    else                   acc_d = sum[ACC_W-1:0];

    pend_d = pend_q;
    if (take_pos) pend_d = pend_d + P_ONE;
    if (take_neg) pend_d = pend_d - P_ONE;
    if (pop) pend_d = pend_q[PQ_W-1] ? pend_d + P_ONE : pend_d - P_ONE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q  <= '0;
      pend_q <= '0;
    end else begin
      acc_q  <= acc_d;
      pend_q <= pend_d;
    end
  end

endmodule

// File: rtl/energy_pulse_seq.sv
module energy_pulse_seq
  import energy_pulse_pkg::*;
#(
  parameter int PW_W = 8,
  parameter int PQ_W = 5
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic signed [PQ_W-1:0]  pend_q,
  input  logic [PW_W-1:0]         pulse_width,
  input  logic                    step_mode,
  output logic                    pop,
  output logic                    out_a,
  output logic                    out_b
);

  seq_state_t      st;
  logic [PW_W-1:0] cnt, pw_eff;
  logic            dir_q;
  logic [1:0]      ph;

  assign pw_eff = (pulse_width == '0) ? PW_W'(1) : pulse_width;
  assign pop    = (st == SQ_IDLE) && (pend_q != '0);
  assign out_a  = step_mode ? ph[1] : (st != SQ_ACT);
  assign out_b  = step_mode ? ph[0] : dir_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= SQ_IDLE;
      cnt   <= '0;
      dir_q <= 1'b0;
      ph    <= 2'b00;
    end else begin
      unique case (st)
        SQ_IDLE: if (pop) begin
          st    <= SQ_ACT;
          cnt   <= pw_eff - PW_W'(1);
          dir_q <= pend_q[PQ_W-1];
          if (step_mode) ph <= gray_step(ph, pend_q[PQ_W-1]);
        end
        SQ_ACT: if (cnt == '0) begin
          st  <= SQ_GAP;
          cnt <= pw_eff - PW_W'(1);
        end else begin
          cnt <= cnt - PW_W'(1);
        end
        SQ_GAP: if (cnt == '0) st <= SQ_IDLE;
                else           cnt <= cnt - PW_W'(1);
        default: st <= SQ_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/energy_pulse_gen.sv
module energy_pulse_gen #(
  parameter int PWR_W    = 24,
  parameter int RATE_W   = 16,
  parameter int ACC_W    = PWR_W + RATE_W + 2,
  parameter int TH_SHIFT = 30,
  parameter int PEND_MAX = 15,
  parameter int PW_W     = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    s_valid,
  output logic                    s_ready,
  input  logic signed [PWR_W-1:0] s_power,
  input  logic [RATE_W-1:0]       pulse_rate,
  input  logic [PW_W-1:0]         pulse_width,
  input  logic                    step_mode,
  output logic                    out_a,
  output logic                    out_b
);

  localparam int PQ_W = $clog2(PEND_MAX + 1) + 1;

  logic signed [ACC_W-1:0] acc_q;
  logic signed [PQ_W-1:0]  pend_q;
  logic                    pop;

  assign s_ready = 1'b1;

  energy_pulse_accum #(
    .PWR_W(PWR_W), .RATE_W(RATE_W), .ACC_W(ACC_W),
    .TH_SHIFT(TH_SHIFT), .PEND_MAX(PEND_MAX), .PQ_W(PQ_W)
  ) u_accum (
    .clk(clk), .rst(rst), .smp_valid(s_valid), .smp(s_power),
    .rate(pulse_rate), .pop(pop), .acc_q(acc_q), .pend_q(pend_q)
  );

  energy_pulse_seq #(.PW_W(PW_W), .PQ_W(PQ_W)) u_seq (
    .clk(clk), .rst(rst), .pend_q(pend_q), .pulse_width(pulse_width),
    .step_mode(step_mode), .pop(pop), .out_a(out_a), .out_b(out_b)
  );

endmodule

// File: rtl/energy_pulse_gen_chk.sv
module energy_pulse_gen_chk #(
  parameter int PWR_W    = 24,
  parameter int ACC_W    = 42,
  parameter int PQ_W     = 5,
  parameter int PEND_MAX = 15
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    s_valid,
  input logic [PWR_W-1:0]        s_power,
  input logic                    step_mode,
  input logic                    out_a,
  input logic                    out_b,
  input logic signed [ACC_W-1:0] acc_q,
  input logic signed [PQ_W-1:0]  pend_q,
  input logic                    pop
);

  localparam logic signed [ACC_W-1:0] ACC_HI = {1'b0, {(ACC_W-1){1'b1}}};
  localparam logic signed [PQ_W-1:0]  PMAX   = PQ_W'(PEND_MAX);
  localparam logic signed [PQ_W-1:0]  PMIN   = -PQ_W'(PEND_MAX);

  // R9: the backlog never leaves its bound
  a_r9_backlog_bound: assert property (@(posedge clk) disable iff (rst)
    (pend_q <= PMAX) && (pend_q >= PMIN));

  // R9: with a full backlog and non-negative input the residue stays clipped
  a_r9_clip_hold: assert property (@(posedge clk) disable iff (rst)
    (pend_q == PMAX && !pop && acc_q == ACC_HI && s_valid && !s_power[PWR_W-1])
    |=> acc_q == ACC_HI);

  // R3: sign line steady while a pulse is low
  a_r3_dir_steady: assert property (@(posedge clk) disable iff (rst)
    (!step_mode && $past(!step_mode) && !out_a && $past(!out_a)) |-> $stable(out_b));

  // R5: taking a pulse from the backlog starts a low phase in pulse mode
  a_r5_pop_starts_pulse: assert property (@(posedge clk) disable iff (rst)
    (pop && !step_mode) |=> (step_mode || !out_a));

  // R8: stepper outputs change one bit at a time
  a_r8_gray_move: assert property (@(posedge clk) disable iff (rst)
    (step_mode && $past(step_mode)) |-> $countones({out_a, out_b} ^ $past({out_a, out_b})) <= 1);

endmodule

bind energy_pulse_gen energy_pulse_gen_chk #(
  .PWR_W(PWR_W), .ACC_W(ACC_W), .PQ_W(PQ_W), .PEND_MAX(PEND_MAX)
) u_chk (
  .clk(clk), .rst(rst), .s_valid(s_valid), .s_power(s_power),
  .step_mode(step_mode), .out_a(out_a), .out_b(out_b),
  .acc_q(acc_q), .pend_q(pend_q), .pop(pop)
);

// File: tb/energy_pulse_gen_bench.sv
`timescale 1ns/1ps
module energy_pulse_gen_bench;

  localparam int PWR_W = 6, RATE_W = 3, ACC_W = 11, TH_SHIFT = 4, PEND_MAX = 15, PW_W = 8;
  localparam int QUANT = 1 << TH_SHIFT;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic s_valid = 1'b0;
  logic s_ready;
  logic signed [PWR_W-1:0] s_power = '0;
  logic [RATE_W-1:0] pulse_rate = '0;
  logic [PW_W-1:0] pulse_width = 8'd1;
  logic step_mode = 1'b0;
  logic out_a, out_b;

  always #2.5 clk = ~clk;

  energy_pulse_gen #(
    .PWR_W(PWR_W), .RATE_W(RATE_W), .ACC_W(ACC_W),
    .TH_SHIFT(TH_SHIFT), .PEND_MAX(PEND_MAX), .PW_W(PW_W)
  ) u_energy_pulse_gen (
    .clk(clk), .rst(rst), .s_valid(s_valid), .s_ready(s_ready),
    .s_power(s_power), .pulse_rate(pulse_rate), .pulse_width(pulse_width),
    .step_mode(step_mode), .out_a(out_a), .out_b(out_b)
  );

  int n_vec = 0, n_bad = 0;
  int pos_cnt = 0, neg_cnt = 0, exp_pw = 1;
  int low_run = 0, high_run = 0;
  bit have_rise = 0, prev_a = 1, fall_dir = 0;
  logic [1:0] prev_ab = 2'b00;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int pidx(input logic [1:0] v);
    case (v)
      2'b00: return 0;
      2'b01: return 1;
      2'b11: return 2;
      default: return 3;
    endcase
  endfunction

  // Output monitor, sampled away from the active edge
  always @(negedge clk) begin
    if (rst) begin
      have_rise = 0; prev_a = 1; prev_ab = 2'b00; low_run = 0; high_run = 0;
    end else if (!step_mode) begin
      if (prev_a && !out_a) begin
        if (out_b) neg_cnt++; else pos_cnt++;
        fall_dir = out_b;
        if (have_rise) chk(high_run >= exp_pw, "R7 gap", high_run, exp_pw);
        low_run = 1;
      end else if (!out_a) begin
        low_run++;
        if (out_b != fall_dir) chk(0, "R3 sign moved", out_b, fall_dir);
      end else if (!prev_a && out_a) begin
        chk(low_run == exp_pw, "R6 width", low_run, exp_pw);
        have_rise = 1; high_run = 1;
      end else if (have_rise) begin
        high_run++;
      end
      prev_a = out_a; prev_ab = {out_a, out_b};
    end else begin
      if ({out_a, out_b} != prev_ab) begin
        int d;
        d = (pidx({out_a, out_b}) - pidx(prev_ab)) & 3;
        if (d == 1) pos_cnt++;
        else if (d == 3) neg_cnt++;
        else chk(0, "R8 step jump", d, 1);
      end
      prev_ab = {out_a, out_b}; prev_a = out_a;
    end
  end

  task automatic start_case(input bit m, input int pwv);
    rst = 1'b1; s_valid = 1'b0;
    step_mode = m;
    pulse_width = PW_W'(pwv);
    exp_pw = (pwv == 0) ? 1 : pwv;
    @(posedge clk); #1;
    pos_cnt = 0; neg_cnt = 0;
    @(posedge clk); #1;
    rst = 1'b0;
  endtask

  task automatic feed(input int s, input int r);
    s_valid = 1'b1; s_power = PWR_W'(s); pulse_rate = RATE_W'(r);
    @(posedge clk); #1;
    s_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    // R10 / R1: state right after reset
    start_case(0, 1);
    chk(out_a == 1'b1, "R10 out_a", out_a, 1);
    chk(out_b == 1'b0, "R10 out_b", out_b, 0);
    chk(s_ready == 1'b1, "R1 ready", s_ready, 1);

    // R1 R2 R5 R6: full sweep of sample and rate, single sample each
    for (int s = -32; s < 32; s++) begin
      for (int r = 0; r < 8; r++) begin
        int e, q, pwv;
        pwv = ((s + r) & 1) ? 0 : 2;
        e = s * r;
        q = (e < 0 ? -e : e) / QUANT;
        start_case(0, pwv);
        feed(s, r);
        idle(q * (2 * ((pwv == 0) ? 1 : pwv) + 1) + 20);
        chk(pos_cnt == (e >= 0 ? q : 0), "R2 positive count", pos_cnt, e >= 0 ? q : 0);
        chk(neg_cnt == (e < 0 ? q : 0), "R2 negative count", neg_cnt, e < 0 ? q : 0);
      end
    end

    // R4: remainder carries across samples and signs
    start_case(0, 1);
    feed(10, 1); idle(20);
    chk(pos_cnt == 0, "R4 below quantum", pos_cnt, 0);
    feed(10, 1); idle(20);
    chk(pos_cnt == 1, "R4 carried remainder", pos_cnt, 1);
    feed(-10, 2); idle(20);
    chk(neg_cnt == 1, "R4 cross-sign carry", neg_cnt, 1);
    feed(-15, 1); idle(20);
    chk(neg_cnt == 1, "R4 negative remainder held", neg_cnt, 1);
    feed(-1, 1); idle(20);
    chk(neg_cnt == 2, "R4 negative remainder completes", neg_cnt, 2);

    // R9: backlog fills and residue clips at 1023 -> 16 + 63 pulses, remainder 15
    start_case(0, 100);
    for (int i = 0; i < 40; i++) feed(31, 7);
    idle(79 * 201 + 100);
    chk(pos_cnt == 79, "R9 clipped total", pos_cnt, 79);
    chk(neg_cnt == 0, "R9 no negative", neg_cnt, 0);
    feed(1, 1); idle(300);
    chk(pos_cnt == 80, "R9 remainder after clip", pos_cnt, 80);

    // R10: reset clears the residue left above
    start_case(0, 1);
    feed(15, 1); idle(20);
    chk(pos_cnt == 0, "R10 residue cleared", pos_cnt, 0);

    // R8: stepper forward then backward
    start_case(1, 2);
    feed(20, 5); idle(6 * 5 + 20);
    chk(pos_cnt == 6, "R8 forward steps", pos_cnt, 6);
    chk({out_a, out_b} == 2'b11, "R8 phase after 6", {out_a, out_b}, 3);
    feed(-20, 5); idle(6 * 5 + 20);
    chk(neg_cnt == 6, "R8 backward steps", neg_cnt, 6);
    chk({out_a, out_b} == 2'b00, "R8 phase home", {out_a, out_b}, 0);
    feed(-3, 7); idle(30);
    chk(neg_cnt == 7, "R8 one more back", neg_cnt, 7);
    chk({out_a, out_b} == 2'b10, "R8 phase 10", {out_a, out_b}, 2);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule